// File: doc/BRIEF.md
# Multifunction FP32 Range Reduction Stage

This stage sits at the front of a shared quadratic-interpolation unit that evaluates seven single-precision functions: base-2 exponential, base-2 logarithm, reciprocal, square root, reciprocal square root, and the scaled sine and cosine sin(πx/2) and cos(πx/2). It takes one normal FP32 operand and a function code. From them it produces the operands the later stages use: a 7-bit coefficient-table index, a 17-bit unsigned fixed-point offset into the selected interval, an 8-bit signed exponent and a sign bit. All of these are registered, so they appear one cycle after the input.

The logarithm, reciprocal and root functions use the significand directly. Its high bits pick the interval, its low bits form the offset, and the unbiased exponent is passed through. The two root functions replace index bit 6 with the exponent parity, which selects between an even table and an odd table. The exponential and trigonometric functions first turn the operand into two's-complement fixed point, then split it into floor and fraction. The trigonometric functions fold the fraction by quadrant, so that one quarter-period sine table covers the whole period.

Special values, out-of-range operands, table lookup, polynomial evaluation and result assembly are handled by other stages.

Top module: `rr_stage`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock. A synchronous active-low reset clears `valid_o`, `idx_o`, `xl_o`, `exp_o` and `sgn_o` to zero.
- R2: In a cycle where `valid_i` is low, `idx_o`, `xl_o`, `exp_o` and `sgn_o` keep their previous values, whatever `a_i` and `fn_i` are doing.
- R3: Function codes on `fn_i`: 0 = EXP2, 1 = LOG2, 2 = RCP, 3 = SQRT, 4 = RSQRT, 5 = SIN, 6 = COS. Code 7 is reserved and produces all-zero data outputs.
- R4: For LOG2, with stored significand m = `a_i[22:0]` and E = `a_i[30:23]` − 127:
  - `idx_o` = {0, m[22:17]}
  - `xl_o` = m[16:0]
  - `exp_o` = E
  - `sgn_o` = `a_i[31]`
- R5: For RCP:
  - `idx_o` = m[22:16], using all 7 index bits
  - `xl_o` = {m[15:0], 0}
  - `exp_o` = E
  - `sgn_o` = `a_i[31]`
- R6: For SQRT and RSQRT:
  - `idx_o` = {E mod 2, m[22:17]}
  - `xl_o` = m[16:0]
  - `exp_o` = E
  - `sgn_o` = `a_i[31]`
- R7: For EXP2, SIN and COS, the operand is converted to a 31-bit two's-complement fixed-point value X:
  - X has 23 fraction bits and keeps its value modulo 256.
  - The conversion truncates |x| to a multiple of 2^-23, then negates the result for negative x.
  - I = X[30:23] is floor(x) mod 256, and F = X[22:0] lies in [0, 1). A negative integer therefore gives F = 0.
- R8: For EXP2:
  - `idx_o` = {0, F[22:17]}
  - `xl_o` = F[16:0]
  - `exp_o` = I
  - `sgn_o` = 0
- R9: For SIN, the quadrant is q = I mod 4. Let t = ~F (that is, 1 − F − 2^-23) when q[0] = 1, and t = F otherwise. Then:
  - `idx_o` = {0, t[22:17]}
  - `xl_o` = t[16:0]
  - `exp_o` = 0
  - `sgn_o` = q[1]
- R10: COS follows R9 exactly, except that the quadrant is q = (I + 1) mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Operand valid |
| fn_i | input | 3 | Function code |
| a_i | input | 32 | FP32 operand (normal) |
| valid_o | output | 1 | Outputs valid |
| idx_o | output | 7 | Coefficient table index |
| xl_o | output | 17 | Unsigned fixed-point interval offset |
| exp_o | output | 8 | Signed exponent or integer part |
| sgn_o | output | 1 | Result sign |

## Verification
The assertions relate each registered output to the operand and code sampled one clock earlier. They assume that every accepted operand is a normal number, with a biased exponent from 1 to 254, because the earlier screening stage has already removed zeros, subnormals, infinities and NaNs. The random stimulus always draws biased exponents inside that range. Half of the draws are clustered near unity so that the fixed-point paths see integer parts that matter. The directed cases cover quadrant boundaries, negative integers, exponent parity and the reserved code.

// File: rtl/rr_pkg.sv
// Package for the range reduction stage.
// Defines the function codes and every operand width the stage uses.
// Assumes IEEE single-precision layout on the operand.
package rr_pkg;
    localparam int FP_MAN_W  = 23;
    localparam int FP_EXP_W  = 8;
    localparam int FP_BIAS   = 127;
    localparam int RR_IDX_W  = 7;
    localparam int RR_XL_W   = 17;
    localparam int RR_EXP_W  = 8;
    localparam int RR_FRAC_W = RR_IDX_W - 1 + RR_XL_W;   // fraction bits of the fixed-point form
    localparam int RR_FIX_W  = RR_EXP_W + RR_FRAC_W;     // integer bits plus fraction bits

    typedef enum logic [2:0] {
        FN_EXP2  = 3'd0,
        FN_LOG2  = 3'd1,
        FN_RCP   = 3'd2,
        FN_SQRT  = 3'd3,
        FN_RSQRT = 3'd4,
        FN_SIN   = 3'd5,
        FN_COS   = 3'd6,
        FN_RSVD  = 3'd7
    } rr_fn_e;

    typedef struct packed {
        logic [RR_IDX_W-1:0] idx;
        logic [RR_XL_W-1:0]  xl;
        logic [RR_EXP_W-1:0] exp;
        logic                sgn;
    } rr_ops_t;
endpackage

// File: rtl/rr_mant_split.sv
// Significand split used by the logarithm, reciprocal and root functions.
// The high significand bits select the interval and the low bits form the offset.
// For the root functions, index bit 6 is replaced by the exponent parity.
// Assumes a normal operand. Purely combinational.
module rr_mant_split
    import rr_pkg::*;
(
    input  logic [FP_MAN_W-1:0] man_i,
    input  logic [RR_EXP_W-1:0] e_unb_i,
    input  rr_fn_e              fn_i,
    output logic [RR_IDX_W-1:0] idx_o,
    output logic [RR_XL_W-1:0]  xl_o
);
    localparam int NARROW = RR_IDX_W - 1;
    localparam int PAD    = RR_XL_W - (FP_MAN_W - RR_IDX_W);

    // Choose the index and offset split for the selected function.
    always_comb begin
        idx_o = {1'b0, man_i[FP_MAN_W-1 -: NARROW]};
        xl_o  = man_i[RR_XL_W-1:0];
        unique case (fn_i)
            FN_RCP: begin
                idx_o = man_i[FP_MAN_W-1 -: RR_IDX_W];
                xl_o  = {man_i[FP_MAN_W-RR_IDX_W-1:0], {PAD{1'b0}}};
            end
            FN_SQRT, FN_RSQRT: idx_o = {e_unb_i[0], man_i[FP_MAN_W-1 -: NARROW]};
            default: ;
        endcase
    end
endmodule

// File: rtl/rr_fix_split.sv
// Converts an FP32 operand into two's-complement fixed point, modulo 2^RR_EXP_W,
// with RR_FRAC_W fraction bits. The magnitude is truncated before negation,
// so the integer field is floor(x) and the fraction lies in [0, 1).
// Assumes a normal operand. Purely combinational.
module rr_fix_split
    import rr_pkg::*;
(
    input  logic [31:0]           a_i,
    input  logic [RR_EXP_W-1:0]   e_unb_i,
    output logic [RR_EXP_W-1:0]   int_o,
    output logic [RR_FRAC_W-1:0]  frac_o
);
    localparam int SIG_W = FP_MAN_W + 1;

    logic [RR_FIX_W-1:0] sig_ext;
    logic [RR_FIX_W-1:0] mag;
    logic [RR_FIX_W-1:0] fx;
    logic [RR_EXP_W-1:0] rsh;

    // Place the significand so that its binary point lands RR_FRAC_W bits up,
    // then shift it by the unbiased exponent.
    always_comb begin
        sig_ext = {{(RR_FIX_W-SIG_W){1'b0}}, 1'b1, a_i[FP_MAN_W-1:0]};
        rsh     = '0 - e_unb_i;
        if (!e_unb_i[RR_EXP_W-1]) mag = sig_ext << e_unb_i;
        else                      mag = sig_ext >> rsh;
        fx      = a_i[31] ? ('0 - mag) : mag;
        int_o   = fx[RR_FIX_W-1:RR_FRAC_W];
        frac_o  = fx[RR_FRAC_W-1:0];
    end
endmodule

// File: rtl/rr_trig_fold.sv
// Quadrant fold for the scaled sine and cosine.
// The quadrant is the floor mod 4, advanced by one for cosine. An odd quadrant
// mirrors the fraction by bit inversion. Quadrant bit 1 gives the sign.
// Purely combinational.
module rr_trig_fold
    import rr_pkg::*;
(
    input  logic [1:0]            qbase_i,
    input  logic [RR_FRAC_W-1:0]  frac_i,
    input  logic                  is_cos_i,
    output logic [RR_IDX_W-1:0]   idx_o,
    output logic [RR_XL_W-1:0]    xl_o,
    output logic                  sgn_o
);
    logic [1:0]           quad;
    logic [RR_FRAC_W-1:0] t;

    // Advance the quadrant for cosine, then mirror the fraction and split it.
    always_comb begin
        quad  = qbase_i + {1'b0, is_cos_i};
        t     = quad[0] ? ~frac_i : frac_i;
        idx_o = {1'b0, t[RR_FRAC_W-1:RR_XL_W]};
        xl_o  = t[RR_XL_W-1:0];
        sgn_o = quad[1];
    end
endmodule

// File: rtl/rr_stage.sv
// Registered range reduction stage for a shared quadratic interpolator.
// It selects between the significand path and the fixed-point path by function
// code, and registers the resulting operands with a one-cycle valid.
// Assumes that screening upstream delivers only normal operands. There is no stall.
module rr_stage
    import rr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [2:0]           fn_i,
    input  logic [31:0]          a_i,
    output logic                 valid_o,
    output logic [RR_IDX_W-1:0]  idx_o,
    output logic [RR_XL_W-1:0]   xl_o,
    output logic [RR_EXP_W-1:0]  exp_o,
    output logic                 sgn_o
);
    rr_fn_e              fn;
    logic [RR_EXP_W-1:0] e_unb;
    logic [RR_IDX_W-1:0] m_idx, t_idx;
    logic [RR_XL_W-1:0]  m_xl, t_xl;
    logic [RR_EXP_W-1:0] i_part;
    logic [RR_FRAC_W-1:0] f_part;
    logic                t_sgn;
    rr_ops_t             nxt, q;

    // Decode the function code and remove the exponent bias.
    always_comb begin
        fn    = rr_fn_e'(fn_i);
        e_unb = a_i[30:23] - RR_EXP_W'(FP_BIAS);
    end

    rr_mant_split u_mant (
        .man_i   (a_i[FP_MAN_W-1:0]),
        .e_unb_i (e_unb),
        .fn_i    (fn),
        .idx_o   (m_idx),
        .xl_o    (m_xl)
    );

    rr_fix_split u_fix (
        .a_i     (a_i),
        .e_unb_i (e_unb),
        .int_o   (i_part),
        .frac_o  (f_part)
    );

    rr_trig_fold u_trig (
        .qbase_i  (i_part[1:0]),
        .frac_i   (f_part),
        .is_cos_i (fn == FN_COS),
        .idx_o    (t_idx),
        .xl_o     (t_xl),
        .sgn_o    (t_sgn)
    );

    // Pick the operand set that belongs to the selected function.
    always_comb begin
        nxt = '0;
        unique case (fn)
            FN_LOG2, FN_RCP, FN_SQRT, FN_RSQRT: begin
                nxt.idx = m_idx;
                nxt.xl  = m_xl;
                nxt.exp = e_unb;
                nxt.sgn = a_i[31];
            end
            FN_EXP2: begin
                nxt.idx = {1'b0, f_part[RR_FRAC_W-1:RR_XL_W]};
                nxt.xl  = f_part[RR_XL_W-1:0];
                nxt.exp = i_part;
            end
            FN_SIN, FN_COS: begin
                nxt.idx = t_idx;
                nxt.xl  = t_xl;
                nxt.sgn = t_sgn;
            end
            default: nxt = '0;
        endcase
    end

    // Register the operands on every accepted input, and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) q <= nxt;
        end
    end

    assign idx_o = q.idx;
    assign xl_o  = q.xl;
    assign exp_o = q.exp;
    assign sgn_o = q.sgn;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(valid_i)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> ($stable(idx_o) && $stable(xl_o) && $stable(exp_o) && $stable(sgn_o)));

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(fn_i) == 3'd7) |-> (idx_o == '0 && xl_o == '0 && exp_o == '0 && !sgn_o));

    p_narrow_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(fn_i) == 3'd0 || $past(fn_i) == 3'd1 || $past(fn_i) == 3'd5 || $past(fn_i) == 3'd6))
        |-> !idx_o[RR_IDX_W-1]);

    p_root_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(fn_i) == 3'd3 || $past(fn_i) == 3'd4))
        |-> (idx_o[RR_IDX_W-1] == !$past(a_i[23])));

    p_mant_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(fn_i) >= 3'd1 && $past(fn_i) <= 3'd4)
        |-> (sgn_o == $past(a_i[31])));

    p_exp2_positive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && $past(fn_i) == 3'd0) |-> !sgn_o);

    p_trig_exp_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(fn_i) == 3'd5 || $past(fn_i) == 3'd6)) |-> (exp_o == '0));
endmodule

// File: tb/rr_stage_test.sv
module rr_stage_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  fn_i = 3'd0;
    logic [31:0] a_i = 32'h3f80_0000;
    logic        valid_o;
    logic [6:0]  idx_o;
    logic [16:0] xl_o;
    logic [7:0]  exp_o;
    logic        sgn_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rr_stage uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fn_i(fn_i), .a_i(a_i),
        .valid_o(valid_o), .idx_o(idx_o), .xl_o(xl_o), .exp_o(exp_o), .sgn_o(sgn_o)
    );

    // Floor and fraction as defined in R7.
    function automatic void fix_split(input logic [31:0] a, output logic [7:0] ip, output logic [22:0] fp);
        int e;
        logic [63:0] s, mag;
        e = int'(a[30:23]) - 127;
        s = {40'd0, 1'b1, a[22:0]};
        if (e >= 0) mag = (e >= 31) ? 64'd0 : (s << e);
        else        mag = (-e >= 24) ? 64'd0 : (s >> (-e));
        if (a[31]) mag = 64'd0 - mag;
        ip = mag[30:23];
        fp = mag[22:0];
    endfunction

    // Expected packed {idx, xl, exp, sgn} from R3 to R10.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [2:0] f);
        logic [7:0]  e, ip;
        logic [22:0] m, fp, t;
        logic [1:0]  qd;
        e = a[30:23] - 8'd127;
        m = a[22:0];
        fix_split(a, ip, fp);
        case (f)
            3'd1: return {1'b0, m[22:17], m[16:0], e, a[31]};
            3'd2: return {m[22:16], m[15:0], 1'b0, e, a[31]};
            3'd3, 3'd4: return {e[0], m[22:17], m[16:0], e, a[31]};
            3'd0: return {1'b0, fp[22:17], fp[16:0], ip, 1'b0};
            3'd5, 3'd6: begin
                qd = ip[1:0] + ((f == 3'd6) ? 2'd1 : 2'd0);
                t  = qd[0] ? ~fp : fp;
                return {1'b0, t[22:17], t[16:0], 8'd0, qd[1]};
            end
            default: return 33'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd0: return "R8";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3, 3'd4: return "R6";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    logic [32:0] last;

    // Present one operand, then check it one clock later (R1 plus the function rule).
    task automatic apply(input logic [31:0] a, input logic [2:0] f);
        @(negedge clk);
        a_i = a; fn_i = f; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        check("R1", {32'd0, valid_o}, 33'd1);
        last = model(a, f);
        check(req_of(f), {idx_o, xl_o, exp_o, sgn_o}, last);
    endtask

    function automatic logic [31:0] rand_op();
        logic [31:0] r;
        r = $urandom;
        if (r[0]) r[30:23] = 8'd120 + 8'($urandom_range(0, 14));
        else      r[30:23] = 8'($urandom_range(1, 254));
        return r;
    endfunction

    initial begin
        void'($urandom(32'd1234));
        valid_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        valid_i = 1'b0;
        @(negedge clk);
        // R1: state after reset, reached with valid_i held high during reset
        check("R1", {valid_o, idx_o, xl_o, exp_o, sgn_o}, 34'd0);

        apply(32'h3f80_0000, 3'd5);  // SIN 1.0: quadrant 1, mirrored fraction (R9)
        check("R9", {idx_o, xl_o}, {7'h3f, 17'h1ffff});
        apply(32'h3f80_0000, 3'd6);  // COS 1.0: quadrant 2, negative (R10)
        check("R10", {32'd0, sgn_o}, 33'd1);
        apply(32'hbf80_0000, 3'd0);  // EXP2 -1.0: I = -1, F = 0 (R7)
        check("R7", {exp_o, idx_o, xl_o}, {8'hff, 7'd0, 17'd0});
        apply(32'hbf00_0000, 3'd0);  // EXP2 -0.5: I = -1, F = 0.5 (R7)
        check("R7", {exp_o, idx_o}, {8'hff, 7'd32});
        apply(32'h4000_0000, 3'd3);  // SQRT 2.0: odd exponent (R6)
        check("R6", {32'd0, idx_o[6]}, 33'd1);
        apply(32'h4080_0000, 3'd4);  // RSQRT 4.0: even exponent (R6)
        check("R6", {32'd0, idx_o[6]}, 33'd0);
        apply(32'h3f00_0000, 3'd3);  // SQRT 0.5: exponent -1 is odd (R6)
        check("R6", {32'd0, idx_o[6]}, 33'd1);
        apply(32'h3fff_ffff, 3'd2);  // RCP uses all 7 index bits (R5)
        check("R5", {26'd0, idx_o}, 33'h7f);
        apply(32'h4140_0000, 3'd7);  // reserved code (R3)
        apply(32'hc0a0_0000, 3'd6);  // COS -5.0 (R10)
        apply(32'hc019_999a, 3'd5);  // SIN -2.4 (R9)
        apply(32'h3fc0_0000, 3'd1);  // LOG2 1.5 (R4)

        // R2: inputs change while valid_i is low
        @(negedge clk);
        a_i = 32'hdead_beef; fn_i = 3'd2;
        @(negedge clk);
        check("R2", {idx_o, xl_o, exp_o, sgn_o}, last);
        check("R1", {32'd0, valid_o}, 33'd0);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] f;
            f = (i % 50 == 49) ? 3'd7 : 3'($urandom_range(0, 6));
            apply(rand_op(), f);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule